// File: doc/BRIEF.md
# Open-Drain Serial Clock Phase Timer

This block paces the clock line of a two-wire serial bus master. It works in cycles of its own block clock. It decides when the master pulls the clock line low and when it releases it. It also marks, with single-cycle strobes, the points at which a command sequencer changes the data line, samples the data line, issues a start, closes a bit and issues a stop. All durations come from three 32-bit timing words. Each word packs two 16-bit fields.

- `tim_high_i` carries the high-phase count in bits 31:16 and the receive sample offset in bits 15:0.
- `tim_low_i` carries the low-phase count in bits 31:16 and the transmit change offset in bits 15:0.
- `tim_bus_i` carries the bus-free count in bits 31:16 and the start hold count in bits 15:0.

The timer adds fixed extra cycles to each clock phase: 2 to the low phase and 7 to the high phase. Phase fields are limited to the range 1 to 1023. Software normally sets the two offsets near three eighths of the matching phase.

The high phase starts counting only once the synchronized bus clock reads high. A slave that holds the line low therefore stretches the bit. After a stop, the next start waits until the bus-free count has run out. A start request that arrives at the end of a high phase without a stop produces a repeated start.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset all outputs are 0, and the block leaves the clock released until `start_req_i` is seen in the idle state.
- R2: `tick_start_o` pulses in the first cycle of the start hold, with the clock released. `scl_low_o` rises max(tim_bus_i[15:0],1) cycles after that pulse.
- R3: `scl_low_o` stays high for exactly P+2 consecutive cycles, where P is the limited value of tim_low_i[31:16].
- R4: Each phase field (tim_low_i[31:16], tim_high_i[31:16]) of 0 counts as 1, and any value above 1023 counts as 1023.
- R5: The high phase lasts limited(tim_high_i[31:16])+7 counted cycles. Counting starts only after the synchronized `scl_in_i` reads high. If `scl_in_i` rises K cycles after release, `scl_low_o` stays 0 for K+SYNC_STAGES+1+limited(hi)+7 cycles.
- R6: `tick_drive_o` pulses in low cycle number X = tim_low_i[15:0], where the first low cycle is number 0. It does not pulse at all when X is not smaller than the low length.
- R7: `tick_sample_o` pulses in counted high cycle number R = tim_high_i[15:0], which is K+SYNC_STAGES+1+R cycles after release. It does not pulse when R is not smaller than the high length.
- R8: `tick_bit_o` pulses in the cycle right after the last counted high cycle.
- R9: If `stop_req_i` is high in the last high cycle, the clock stays released and `tick_stop_o` pulses. The next `tick_start_o` comes max(tim_bus_i[31:16],1)+1 cycles after `tick_stop_o`, even when `start_req_i` is held high throughout.
- R10: If `start_req_i` is high and `stop_req_i` is low in the last high cycle, a new start hold follows with the clock still released, and `tick_start_o` pulses in the next cycle.
- R11: When both requests are high at the end of a high phase, the stop is taken and no start tick occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tim_high_i | input | 32 | High-phase count [31:16], sample offset [15:0] |
| tim_low_i | input | 32 | Low-phase count [31:16], drive offset [15:0] |
| tim_bus_i | input | 32 | Bus-free count [31:16], start hold count [15:0] |
| scl_in_i | input | 1 | Level of the bus clock line, asynchronous |
| start_req_i | input | 1 | Level request for a start or repeated start |
| stop_req_i | input | 1 | Level request to finish with a stop after the current bit |
| scl_low_o | output | 1 | 1 pulls the clock line low |
| tick_start_o | output | 1 | Start hold begins, data line may fall |
| tick_drive_o | output | 1 | Transmit data change point |
| tick_sample_o | output | 1 | Receive sample point |
| tick_bit_o | output | 1 | High phase of a bit has ended |
| tick_stop_o | output | 1 | Stop point, bus-free wait begins |

## Verification
Every result is due at a fixed cycle offset from an observable edge. A start tick is followed by the low edge after the start hold count. A drive tick falls X cycles into the low phase. A sample tick falls K+3+R cycles after release when the synchronizer has two stages. The bit tick coincides with the first low cycle of the next bit. The next start tick comes bus-free+1 cycles after the stop tick. The bench drives inputs and reads outputs only on falling edges. It counts whole cycles from each reference edge and compares the count against the value computed from the requirement formulas.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;
  // Built-in extra cycles added to each programmed phase count.
  localparam int LOW_EXTRA   = 2;
  localparam int HIGH_EXTRA  = 7;
  // Largest usable phase count.
  localparam int PHASE_LIMIT = 1023;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_LOW,
    PH_WAIT,
    PH_HIGH,
    PH_GAP
  } phase_e;
endpackage

// File: rtl/scl_tgen_sync.sv
module scl_tgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= 1'b0;
        else     pipe[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= 1'b0;
        else     pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/scl_tgen_len.sv
module scl_tgen_len #(
  parameter int FIELD_W = 16,
  parameter int LEN_W   = 17,
  parameter int EXTRA   = 0,
  parameter int LIMIT   = 0
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [LEN_W-1:0]   len_o
);
  logic [FIELD_W-1:0] floored;

  assign floored = (field_i == '0) ? FIELD_W'(1) : field_i;

  if (LIMIT > 0) begin : g_capped
    logic [FIELD_W-1:0] capped;
    assign capped = (floored > FIELD_W'(LIMIT)) ? FIELD_W'(LIMIT) : floored;
    assign len_o  = LEN_W'(capped) + LEN_W'(EXTRA);
  end else begin : g_free
    assign len_o  = LEN_W'(floored) + LEN_W'(EXTRA);
  end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FIELD_W     = 16,
  parameter int REG_W       = 2 * FIELD_W,
  parameter int PHASE_MAX   = PHASE_LIMIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] tim_high_i,
  input  logic [REG_W-1:0] tim_low_i,
  input  logic [REG_W-1:0] tim_bus_i,
  input  logic             scl_in_i,
  input  logic             start_req_i,
  input  logic             stop_req_i,
  output logic             scl_low_o,
  output logic             tick_start_o,
  output logic             tick_drive_o,
  output logic             tick_sample_o,
  output logic             tick_bit_o,
  output logic             tick_stop_o
);
  localparam int CNT_W = FIELD_W + 1;

  logic [FIELD_W-1:0] f_hi, f_rcv, f_lo, f_xmt, f_gap, f_lead;
  logic [CNT_W-1:0]   len_low, len_high, len_lead, len_gap;
  logic [CNT_W-1:0]   cnt, cnt_d, cnt_inc;
  phase_e             st, st_d;
  logic               scl_hi;
  logic               high_last;

  assign f_hi   = tim_high_i[2*FIELD_W-1:FIELD_W];
  assign f_rcv  = tim_high_i[FIELD_W-1:0];
  assign f_lo   = tim_low_i[2*FIELD_W-1:FIELD_W];
  assign f_xmt  = tim_low_i[FIELD_W-1:0];
  assign f_gap  = tim_bus_i[2*FIELD_W-1:FIELD_W];
  assign f_lead = tim_bus_i[FIELD_W-1:0];

  scl_tgen_len #(.FIELD_W(FIELD_W), .LEN_W(CNT_W), .EXTRA(LOW_EXTRA), .LIMIT(PHASE_MAX))
    u_len_low  (.field_i(f_lo),   .len_o(len_low));
  scl_tgen_len #(.FIELD_W(FIELD_W), .LEN_W(CNT_W), .EXTRA(HIGH_EXTRA), .LIMIT(PHASE_MAX))
    u_len_high (.field_i(f_hi),   .len_o(len_high));
  scl_tgen_len #(.FIELD_W(FIELD_W), .LEN_W(CNT_W), .EXTRA(0), .LIMIT(0))
    u_len_lead (.field_i(f_lead), .len_o(len_lead));
  scl_tgen_len #(.FIELD_W(FIELD_W), .LEN_W(CNT_W), .EXTRA(0), .LIMIT(0))
    u_len_gap  (.field_i(f_gap),  .len_o(len_gap));

  scl_tgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (scl_in_i),
    .q_o (scl_hi)
  );

  assign cnt_inc   = cnt + CNT_W'(1);
  assign high_last = (st == PH_HIGH) && (cnt == len_high - CNT_W'(1));

  always_comb begin
    st_d  = st;
    cnt_d = cnt;
    unique case (st)
      PH_IDLE: begin
        if (start_req_i) begin
          st_d  = PH_LEAD;
          cnt_d = '0;
        end
      end
      PH_LEAD: begin
        if (cnt == len_lead - CNT_W'(1)) begin
          st_d  = PH_LOW;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      PH_LOW: begin
        if (cnt == len_low - CNT_W'(1)) begin
          st_d  = PH_WAIT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      PH_WAIT: begin
        if (scl_hi) begin
          st_d  = PH_HIGH;
          cnt_d = '0;
        end
      end
      PH_HIGH: begin
        if (high_last) begin
          cnt_d = '0;
          if (stop_req_i)       st_d = PH_GAP;
          else if (start_req_i) st_d = PH_LEAD;
          else                  st_d = PH_LOW;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      PH_GAP: begin
        if (cnt == len_gap - CNT_W'(1)) begin
          st_d  = PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: begin
        st_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= PH_IDLE;
      cnt           <= '0;
      scl_low_o     <= 1'b0;
      tick_start_o  <= 1'b0;
      tick_drive_o  <= 1'b0;
      tick_sample_o <= 1'b0;
      tick_bit_o    <= 1'b0;
      tick_stop_o   <= 1'b0;
    end else begin
      st            <= st_d;
      cnt           <= cnt_d;
      scl_low_o     <= (st_d == PH_LOW);
      tick_start_o  <= (st_d == PH_LEAD) && (st != PH_LEAD);
      tick_drive_o  <= (st_d == PH_LOW)  && (cnt_d == {1'b0, f_xmt});
      tick_sample_o <= (st_d == PH_HIGH) && (cnt_d == {1'b0, f_rcv});
      tick_bit_o    <= high_last;
      tick_stop_o   <= (st_d == PH_GAP) && (st != PH_GAP);
    end
  end
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic clk,
  input logic rst,
  input logic scl_low_o,
  input logic tick_start_o,
  input logic tick_drive_o,
  input logic tick_sample_o,
  input logic tick_bit_o,
  input logic tick_stop_o
);
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) $fell(rst) |-> !scl_low_o && !tick_stop_o); // R1
  AST_START_RELEASED: assert property (@(posedge clk) disable iff (rst) tick_start_o |-> !scl_low_o); // R2
  AST_LOW_MIN_LEN: assert property (@(posedge clk) disable iff (rst) $rose(scl_low_o) |=> scl_low_o ##1 scl_low_o); // R4
  AST_DRIVE_IN_LOW: assert property (@(posedge clk) disable iff (rst) tick_drive_o |-> scl_low_o); // R6
  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (rst) tick_sample_o |-> !scl_low_o); // R7
  AST_BIT_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst) tick_bit_o |-> !$past(scl_low_o)); // R8
  AST_STOP_RELEASED: assert property (@(posedge clk) disable iff (rst) tick_stop_o |-> !scl_low_o); // R9
  AST_STOP_HOLDOFF: assert property (@(posedge clk) disable iff (rst) tick_stop_o |=> !tick_start_o); // R9
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (rst) tick_stop_o |-> !tick_start_o); // R11
  AST_STROBE_SPLIT: assert property (@(posedge clk) disable iff (rst) $onehot0({tick_drive_o, tick_sample_o, tick_stop_o})); // R6
endmodule

bind scl_timing_gen scl_timing_gen_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .scl_low_o     (scl_low_o),
  .tick_start_o  (tick_start_o),
  .tick_drive_o  (tick_drive_o),
  .tick_sample_o (tick_sample_o),
  .tick_bit_o    (tick_bit_o),
  .tick_stop_o   (tick_stop_o)
);

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tim_high = '0, tim_low = '0, tim_bus = '0;
  logic        start_req = 1'b0, stop_req = 1'b0, hold = 1'b0;
  logic        scl_in;
  logic        scl_low, t_start, t_drive, t_sample, t_bit, t_stop;
  int          tests = 0, fails = 0;

  always #2 clk = ~clk;

  // Open-drain line: low when the master pulls or the slave stretches.
  assign scl_in = !scl_low && !hold;

  scl_timing_gen dut_i (
    .clk (clk), .rst (rst),
    .tim_high_i (tim_high), .tim_low_i (tim_low), .tim_bus_i (tim_bus),
    .scl_in_i (scl_in), .start_req_i (start_req), .stop_req_i (stop_req),
    .scl_low_o (scl_low), .tick_start_o (t_start), .tick_drive_o (t_drive),
    .tick_sample_o (t_sample), .tick_bit_o (t_bit), .tick_stop_o (t_stop)
  );

  // lo, hi, drive offset, sample offset, lead, gap, stretch cycles
  localparam int NV = 5;
  localparam int VEC [NV][7] = '{
    '{5,    4,    2,    1,    3, 4, 0},
    '{0,    0,    0,    0,    0, 0, 0},
    '{10,   12,   4,    5,    6, 9, 5},
    '{2000, 5000, 1024, 1029, 2, 3, 2},
    '{3,    2,    9,    20,   1, 2, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lim(input int v);
    return (v == 0) ? 1 : ((v > 1023) ? 1023 : v);
  endfunction

  function automatic int one(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic run_vec(input int lo, input int hi, input int xo, input int ro,
                         input int ld, input int gp, input int k);
    int lowlen, highlen, n, didx, sidx;
    lowlen  = lim(lo) + 2;
    highlen = lim(hi) + 7;
    @(negedge clk);
    tim_high  = {16'(hi), 16'(ro)};
    tim_low   = {16'(lo), 16'(xo)};
    tim_bus   = {16'(gp), 16'(ld)};
    hold      = (k > 0);
    start_req = 1'b1;
    while (!t_start) @(negedge clk);
    start_req = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!scl_low);
    chk("R2 start hold", n, one(ld));
    didx = -1; n = 0;
    while (scl_low) begin
      if (t_drive) didx = n;
      n++;
      @(negedge clk);
    end
    chk((lo == 0 || lo > 1023) ? "R4 low limit" : "R3 low length", n, lowlen);
    chk("R6 drive point", didx, (xo < lowlen) ? xo : -1);
    sidx = -1; n = 0;
    while (!scl_low) begin
      if (n == k) hold = 1'b0;
      if (t_sample) sidx = n;
      n++;
      @(negedge clk);
    end
    chk((hi == 0 || hi > 1023) ? "R4 high limit" : "R5 high length", n, k + 3 + highlen);
    chk("R7 sample point", sidx, (ro < highlen) ? k + 3 + ro : -1);
    chk("R8 bit tick", int'(t_bit), 1);
    stop_req = 1'b1;
    while (!t_stop) @(negedge clk);
    start_req = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!t_start);
    chk("R9 bus free", n, one(gp) + 1);
    start_req = 1'b0;
    while (!t_stop) @(negedge clk);
    stop_req = 1'b0;
    repeat (one(gp) + 3) @(negedge clk);
    chk("R1 idle after stop", int'(scl_low), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int act, n, sidx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state and no activity without a request
    act = 0;
    repeat (12) begin
      @(negedge clk);
      act += int'(scl_low) + int'(t_start) + int'(t_drive) + int'(t_sample) + int'(t_bit) + int'(t_stop);
    end
    chk("R1 reset idle", act, 0);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);

    // R10: repeated start; hi=3 gives 10 counted cycles, lead 2
    @(negedge clk);
    tim_high = {16'd3, 16'd1};
    tim_low  = {16'd4, 16'd1};
    tim_bus  = {16'd2, 16'd2};
    start_req = 1'b1;
    while (!t_start) @(negedge clk);
    start_req = 1'b0;
    while (!scl_low) @(negedge clk);
    while (scl_low) @(negedge clk);
    start_req = 1'b1;
    n = 0; sidx = -1;
    while (!scl_low) begin
      if (t_start) sidx = n;
      n++;
      @(negedge clk);
    end
    chk("R10 restart released length", n, 3 + 10 + 2);
    chk("R10 restart tick position", sidx, 13);
    // R11: both requests at end of high -> stop wins
    stop_req = 1'b1;
    while (!t_stop && !t_start) @(negedge clk);
    chk("R11 stop taken", int'(t_stop), 1);
    chk("R11 no start tick", int'(t_start), 0);
    start_req = 1'b0;
    stop_req  = 1'b0;
    act = 0;
    repeat (10) begin @(negedge clk); act += int'(scl_low) + int'(t_start); end
    chk("R1 idle after stop", act, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule